// File: doc/BRIEF.md
# Parallel-Capture Serial Scan Unit

This unit gives a memory device a simple test path that needs no TAP controller and no instruction register. While one level-sensitive scan-enable input is high, a capture strobe samples 67 input pin values into a shift chain in one clock. A shift strobe then walks the chain toward a single output. That output shares a pin with a normal data-strobe signal. Once the last captured bit has left, the chain keeps shifting out zeros, because its far end is fed by a constant 0.

Two chain positions are reserved and always read back as 0. While scan mode is active, the pin-mirroring function is forced off. Dropping scan-enable clears the chain and the scan output-enable at once, without waiting for a clock. The shared strobe pin and the mirroring control then go back to their normal drivers.

Top module: `pscan_unit`

## Requirements
- R1: After reset, the shared pin's output-enable and value equal `func_strobe_oe` and `func_strobe`.
- R2: With `scan_en` high and `capture` high at a clock edge, all 67 positions load in that edge. Position k takes `pins_in[k-1]`. Bit 1 is on `strobe_pin` from the next cycle.
- R3: When `capture` and `shift` are both high, the capture wins. Bit 1, not bit 2, is presented afterwards.
- R4: Each edge with `scan_en` and `shift` high (and `capture` low) advances the chain by one place. After n shifts, bit n+1 is on `strobe_pin`.
- R5: Positions 56 and 57 read as 0 whatever `pins_in[55]` and `pins_in[56]` hold.
- R6: Once bit 67 has been presented, every further shift presents 0. This is checked for at least 10 extra shifts.
- R7: With `scan_en` high and both `capture` and `shift` low, the chain and `strobe_pin` hold their value.
- R8: Driving `scan_en` low clears the chain and the scan output-enable at once, with no clock edge. `strobe_pin` and `strobe_oe` then follow `func_strobe` and `func_strobe_oe`.
- R9: The scan output-enable rises at the first clock edge with `scan_en` high. While it is set, `strobe_oe` is 1 and `strobe_pin` carries the chain head.
- R10: `mirror_on` is 0 while `scan_en` is high, and equals `mirror_req` while it is low.
- R11: `capture` and `shift` have no effect while `scan_en` is low. After `scan_en` rises, the chain reads as all zeros until a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Scan mode select, level sensitive |
| capture | input | 1 | Parallel load strobe |
| shift | input | 1 | Serial advance strobe |
| pins_in | input | 67 | Sampled pin values, bit k-1 is chain position k |
| func_strobe | input | 1 | Normal-mode strobe value |
| func_strobe_oe | input | 1 | Normal-mode strobe enable |
| mirror_req | input | 1 | Normal-mode mirroring request |
| strobe_pin | output | 1 | Shared strobe / scan output value |
| strobe_oe | output | 1 | Shared pin output-enable |
| mirror_on | output | 1 | Effective mirroring control |

## Verification
A wrong internal state shows up as a misplaced bit on `strobe_pin`. The fault is visible in the cycle right after the shift that brings the bad position to the head. A lost capture or a priority error shows in the very next cycle, because bit 1 is wrong. A chain that fails to clear when `scan_en` drops shows only after scan mode is re-entered, so the bench re-enters and shifts without a capture. A fill fault shows as a 1 in the stream after bit 67.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic {
        PIN_FUNC = 1'b0,
        PIN_SCAN = 1'b1
    } pin_src_e;
endpackage

// File: rtl/scan_cap_mask.sv
module scan_cap_mask #(
    parameter int LEN   = 67,
    parameter int RSV_A = 56,
    parameter int RSV_B = 57
) (
    input  logic [LEN-1:0] raw_i,
    output logic [LEN-1:0] masked_o
);
    for (genvar g = 0; g < LEN; g++) begin : g_pos
        if ((g + 1 == RSV_A) || (g + 1 == RSV_B)) begin : g_rsv
            assign masked_o[g] = 1'b0;
        end else begin : g_live
            assign masked_o[g] = raw_i[g];
        end
    end
endmodule

// File: rtl/scan_chain_core.sv
module scan_chain_core #(
    parameter int LEN   = 67,
    parameter int RSV_A = 56,
    parameter int RSV_B = 57
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_en,
    input  logic           capture,
    input  logic           shift,
    input  logic [LEN-1:0] load_i,
    output logic           head_o,
    output logic           oe_o
);
    typedef struct packed {
        logic [LEN-1:0] chain;
        logic           oe;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     clr_n;

    assign clr_n = rst_n & scan_en;

    always_comb begin
        st_d    = st_q;
        st_d.oe = 1'b1;
        if (capture) begin
            st_d.chain = load_i;
        end else if (shift) begin
            st_d.chain = {1'b0, st_q.chain[LEN-1:1]};
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o = st_q.chain[0];
    assign oe_o   = st_q.oe;

    // R8: scan output-enable never seen set while scan mode is off
    a_r8_oe_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> !oe_o);
    // R3: capture wins over shift, bit 1 at head next cycle
    a_r3_capture_prio: assert property (@(posedge clk) disable iff (!clr_n)
        (capture && shift) |=> (head_o == $past(load_i[0])));
    // R4: a shift brings the former second position to the head
    a_r4_shift_step: assert property (@(posedge clk) disable iff (!clr_n)
        (shift && !capture) |=> (head_o == $past(st_q.chain[1])));
    // R6: far end filled with zero on every shift
    a_r6_zero_fill: assert property (@(posedge clk) disable iff (!clr_n)
        (shift && !capture) |=> (st_q.chain[LEN-1] == 1'b0));
    // R5: reserved positions empty right after capture
    a_r5_reserved: assert property (@(posedge clk) disable iff (!clr_n)
        capture |=> (st_q.chain[RSV_A-1] == 1'b0 && st_q.chain[RSV_B-1] == 1'b0));
    // R7: no strobe means the head holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (!capture && !shift && oe_o) |=> $stable(head_o));
endmodule

// File: rtl/scan_pin_mux.sv
module scan_pin_mux
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic scan_oe,
    input  logic scan_bit,
    input  logic func_strobe,
    input  logic func_strobe_oe,
    input  logic mirror_req,
    output logic strobe_pin,
    output logic strobe_oe,
    output logic mirror_on
);
    pin_src_e src;

    assign src = scan_oe ? PIN_SCAN : PIN_FUNC;

    always_comb begin
        case (src)
            PIN_SCAN: begin
                strobe_pin = scan_bit;
                strobe_oe  = 1'b1;
            end
            default: begin
                strobe_pin = func_strobe;
                strobe_oe  = func_strobe_oe;
            end
        endcase
        mirror_on = mirror_req & ~scan_en;
    end

    // R10: mirroring forced off in scan mode
    a_r10_mirror_off: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !mirror_on);
    // R9: pin enabled whenever the scan path owns it
    a_r9_pin_driven: assert property (@(posedge clk) disable iff (!rst_n)
        scan_oe |-> (strobe_oe && strobe_pin == scan_bit));
endmodule

// File: rtl/pscan_unit.sv
module pscan_unit #(
    parameter int LEN   = 67,
    parameter int RSV_A = 56,
    parameter int RSV_B = 57
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_en,
    input  logic           capture,
    input  logic           shift,
    input  logic [LEN-1:0] pins_in,
    input  logic           func_strobe,
    input  logic           func_strobe_oe,
    input  logic           mirror_req,
    output logic           strobe_pin,
    output logic           strobe_oe,
    output logic           mirror_on
);
    logic [LEN-1:0] load_w;
    logic           head_w;
    logic           oe_w;

    scan_cap_mask #(.LEN(LEN), .RSV_A(RSV_A), .RSV_B(RSV_B)) u_mask (
        .raw_i   (pins_in),
        .masked_o(load_w)
    );

    scan_chain_core #(.LEN(LEN), .RSV_A(RSV_A), .RSV_B(RSV_B)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .scan_en(scan_en),
        .capture(capture),
        .shift  (shift),
        .load_i (load_w),
        .head_o (head_w),
        .oe_o   (oe_w)
    );

    scan_pin_mux u_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_en       (scan_en),
        .scan_oe       (oe_w),
        .scan_bit      (head_w),
        .func_strobe   (func_strobe),
        .func_strobe_oe(func_strobe_oe),
        .mirror_req    (mirror_req),
        .strobe_pin    (strobe_pin),
        .strobe_oe     (strobe_oe),
        .mirror_on     (mirror_on)
    );
endmodule

// File: tb/pscan_unit_tb.sv
`timescale 1ns/1ps
module pscan_unit_tb;
    localparam int LEN   = 67;
    localparam int EXTRA = 10;

    localparam logic [LEN-1:0] PATS [0:3] = '{
        67'h7_FFFF_FFFF_FFFF_FFFF,
        67'h2_5A5A_C3C3_1234_9876,
        67'h5_0F0F_F0F0_DEAD_BEEF,
        67'h0_0000_0000_0000_0001
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           scan_en = 1'b0;
    logic           capture = 1'b0;
    logic           shift = 1'b0;
    logic [LEN-1:0] pins_in = '0;
    logic           func_strobe = 1'b1;
    logic           func_strobe_oe = 1'b0;
    logic           mirror_req = 1'b1;
    logic           strobe_pin, strobe_oe, mirror_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pscan_unit #(.LEN(LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .capture(capture),
        .shift(shift), .pins_in(pins_in), .func_strobe(func_strobe),
        .func_strobe_oe(func_strobe_oe), .mirror_req(mirror_req),
        .strobe_pin(strobe_pin), .strobe_oe(strobe_oe), .mirror_on(mirror_on)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [LEN-1:0] p, input int k);
        if (k > LEN || k == 56 || k == 57) return 1'b0;
        return p[k-1];
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, pin follows normal function
        chk("R1 oe", strobe_oe, 1'b0);
        chk("R1 pin", strobe_pin, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after release", strobe_oe, 1'b0);
        chk("R10 mirror normal", mirror_on, 1'b1);

        // table walk: R2 R4 R5 R6 R9
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            scan_en = 1'b1; capture = 1'b1; shift = 1'b0; pins_in = PATS[p];
            #0.5 chk("R10 mirror forced off", mirror_on, 1'b0);
            @(negedge clk);
            chk("R9 scan oe", strobe_oe, 1'b1);
            chk("R2 bit1", strobe_pin, exp_bit(PATS[p], 1));
            capture = 1'b0; shift = 1'b1;
            for (int k = 2; k <= LEN + EXTRA; k++) begin
                @(negedge clk);
                if (k == 56 || k == 57)
                    chk("R5 reserved zero", strobe_pin, 1'b0);
                else if (k > LEN)
                    chk("R6 zero fill", strobe_pin, 1'b0);
                else
                    chk("R4 order", strobe_pin, exp_bit(PATS[p], k));
            end
            shift = 1'b0;
            @(negedge clk);
            scan_en = 1'b0;
        end

        // R3: capture beats shift
        @(negedge clk);
        scan_en = 1'b1; capture = 1'b1; shift = 1'b1; pins_in = 67'h1;
        @(negedge clk);
        chk("R3 capture priority", strobe_pin, 1'b1);
        capture = 1'b0; shift = 1'b0;
        // R7: hold
        repeat (3) @(negedge clk);
        chk("R7 hold", strobe_pin, 1'b1);
        shift = 1'b1;
        @(negedge clk);
        chk("R4 second bit", strobe_pin, 1'b0);
        shift = 1'b0;

        // R8: async clear, pin back to normal mid-cycle
        @(negedge clk);
        capture = 1'b1; pins_in = 67'h1;
        @(negedge clk);
        capture = 1'b0;
        func_strobe = 1'b0; func_strobe_oe = 1'b1;
        #1 scan_en = 1'b0;
        #0.5;
        chk("R8 pin value normal", strobe_pin, 1'b0);
        chk("R8 pin oe normal", strobe_oe, 1'b1);
        chk("R10 mirror restored", mirror_on, 1'b1);

        // R11: strobes ignored with scan_en low
        @(negedge clk);
        capture = 1'b1; pins_in = '1;
        @(negedge clk);
        capture = 1'b0; shift = 1'b1;
        @(negedge clk);
        shift = 1'b0;
        chk("R11 pin still normal", strobe_oe, 1'b1);
        scan_en = 1'b1;
        @(negedge clk);
        chk("R11 chain empty head", strobe_pin, 1'b0);
        chk("R9 oe after entry", strobe_oe, 1'b1);
        shift = 1'b1;
        @(negedge clk);
        chk("R11 chain empty bit2", strobe_pin, 1'b0);
        shift = 1'b0;
        scan_en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule